// File: doc/BRIEF.md
# Speculative Lock Acquire and Release Detector

This block watches the stream of retiring memory instructions from one processor core. It spots the pattern a software lock produces: a load-locked followed by a store-conditional to the same address. When it sees that pattern it predicts that the lock is not needed. It suppresses the store-conditional, and the core then runs the critical section speculatively. At that entry the block saves the lock address and the value the load-locked read, which is the value the lock held before the acquire store.

A later plain store to the lock address that writes the saved value back is taken as the lock release. That store is also suppressed, and the block issues a one-cycle commit pulse. The speculation ends in an abort pulse in four cases:
- the store to the lock address carries any other value;
- a data conflict is reported;
- a speculative buffer runs out of space;
- an uncached access or an untrackable event occurs.

The core then restarts and takes the lock for real. For that retry the block remembers the failed lock address in a one-entry register. The next acquire of that address is therefore let through without elision. The entry clears when the real acquire is released.

Top module: `lock_elide_ctrl`

## Requirements
- R1: After reset, `elide_store`, `spec_mode`, `commit` and `abort_lock` are all 0.
- R2: A retired load-locked (kind 3) to address A, followed later by a store-conditional (kind 4) to A with no plain store to A in between, raises `elide_store` combinationally in the store-conditional's retire cycle. `spec_mode` is 1 from the following cycle.
- R3: Only load-locked and store-conditional start detection. A plain load (kind 1) followed by a store-conditional, or a load-locked whose address is hit by a plain store (kind 2) before the store-conditional, gives no elision and no speculation. Kind 0 means no memory access.
- R4: A store-conditional to an address other than the armed load-locked address is not elided and does not start speculation.
- R5: During speculation, a plain store to the lock address whose data equals the value read by the load-locked is elided in its retire cycle. `commit` is 1 for exactly the next cycle, and `spec_mode` is 0 in that same cycle.
- R6: During speculation, a plain store to the lock address with any other data is not elided. `abort_lock` is 1 in the next cycle.
- R7: During speculation, `conflict` or `buf_full` high in a cycle gives `abort_lock` in the next cycle, with `spec_mode` 0 in that cycle.
- R8: During speculation, `untracked_evt` high, or a retired access with `ret_uncached` high, gives `abort_lock` in the next cycle.
- R9: After an abort on lock address A, the next acquire of A is not elided and speculation does not start. An acquire of a different address is still elided.
- R10: The blocked acquire of A ends when a plain store writes the saved value back to A. That store is not elided, and the following acquire of A is elided again.
- R11: `commit` and `abort_lock` each last a single cycle and are never high together. When a restoring release and an abort cause come in the same cycle, the abort wins: `abort_lock` rises, and neither `commit` nor `elide_store` does.
- R12: Abort causes outside speculation are ignored. They raise no `abort_lock` and do not disturb a pending load-locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | 1 | A memory instruction retires this cycle |
| ret_kind | input | 3 | 0 none, 1 load, 2 store, 3 load-locked, 4 store-conditional |
| ret_addr | input | ADDR_W | Address of the retiring access |
| ret_ldval | input | DATA_W | Value read by a retiring load or load-locked |
| ret_stdata | input | DATA_W | Data of a retiring store or store-conditional |
| ret_uncached | input | 1 | The retiring access is uncached |
| conflict | input | 1 | Data conflict detected by coherence |
| buf_full | input | 1 | Speculative buffering resources exhausted |
| untracked_evt | input | 1 | Event whose requests cannot be tracked |
| elide_store | output | 1 | Suppress the retiring store (combinational) |
| spec_mode | output | 1 | Speculative critical section in progress |
| commit | output | 1 | One-cycle pulse: commit speculative state |
| abort_lock | output | 1 | One-cycle pulse: discard speculation, take the lock |

## Verification
The in-line assertions check these properties on every cycle:
- pulse exclusivity and single-cycle width;
- that elision happens only on stores;
- entry into speculation after an elided acquire;
- abort one cycle after any cause seen while speculating;
- the drop of `spec_mode` when commit fires;
- no speculation after a blocked acquire.

Only the bench's scenarios can show the rest:
- that the saved value comes from the load-locked and is the one matched at release;
- that a non-candidate load or an intervening store defeats detection;
- that the blocking entry covers one address and clears only on the real release.

The bench sweeps addresses, lock values and each abort cause to cover these.

// File: rtl/lock_elide_pkg.sv
package lock_elide_pkg;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_LOAD  = 3'd1,
    K_STORE = 3'd2,
    K_LL    = 3'd3,
    K_SC    = 3'd4
  } ret_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ARMED = 2'd1,
    S_SPEC  = 2'd2,
    S_HELD  = 2'd3
  } le_state_e;

  // number of distinct misspeculation causes
  localparam int NCAUSE = 4;

  function automatic logic is_store_kind(input logic [2:0] k);
    return (k == K_STORE) || (k == K_SC);
  endfunction

endpackage

// File: rtl/lock_elide_decode.sv
module lock_elide_decode
  import lock_elide_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              ret_valid,
  input  logic [2:0]        ret_kind,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic [ADDR_W-1:0] lock_addr,
  output logic              ev_ll,
  output logic              ev_sc,
  output logic              ev_st,
  output logic              hit_arm,
  output logic              hit_lock
);

  function automatic logic addr_eq(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] b);
    return a == b;
  endfunction

  assign ev_ll    = ret_valid && (ret_kind == K_LL);
  assign ev_sc    = ret_valid && (ret_kind == K_SC);
  assign ev_st    = ret_valid && (ret_kind == K_STORE);
  assign hit_arm  = addr_eq(ret_addr, arm_addr);
  assign hit_lock = addr_eq(ret_addr, lock_addr);

endmodule

// File: rtl/lock_elide_causes.sv
module lock_elide_causes
  import lock_elide_pkg::*;
(
  input  logic ret_valid,
  input  logic ret_uncached,
  input  logic conflict,
  input  logic buf_full,
  input  logic untracked_evt,
  output logic cause_any
);

  logic [NCAUSE-1:0] cause_vec;

  function automatic logic any_set(input logic [NCAUSE-1:0] v);
    return |v;
  endfunction

  assign cause_vec = {untracked_evt, ret_valid && ret_uncached, buf_full, conflict};
  assign cause_any = any_set(cause_vec);

endmodule

// File: rtl/lock_elide_block.sv
module lock_elide_block #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              blocked
);

  logic              ent_v;
  logic [ADDR_W-1:0] ent_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v    <= 1'b0;
      ent_addr <= '0;
    end else if (set_en) begin
      ent_v    <= 1'b1;
      ent_addr <= set_addr;
    end else if (clr_en) begin
      ent_v    <= 1'b0;
    end
  end

  assign blocked = ent_v && (ent_addr == query_addr);

  // R10: a cleared entry never blocks on the following cycle
  p_clear_unblocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !blocked);

endmodule

// File: rtl/lock_elide_fsm.sv
module lock_elide_fsm
  import lock_elide_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [DATA_W-1:0] ret_ldval,
  input  logic [DATA_W-1:0] ret_stdata,
  input  logic              ev_ll,
  input  logic              ev_sc,
  input  logic              ev_st,
  input  logic              hit_arm,
  input  logic              hit_lock,
  input  logic              cause_any,
  input  logic              blocked,
  output logic [ADDR_W-1:0] arm_addr,
  output logic [ADDR_W-1:0] lock_addr,
  output logic              elide_store,
  output logic              spec_mode,
  output logic              commit,
  output logic              abort_lock,
  output logic              ne_set,
  output logic              ne_clr,
  output logic              entry_evt,
  output logic              blocked_evt
);

  le_state_e         st_q, st_d;
  logic [DATA_W-1:0] arm_val, lock_val;
  logic              commit_d, abort_d;
  logic              release_evt, mismatch_evt;

  function automatic logic restores(input logic [DATA_W-1:0] saved,
                                    input logic [DATA_W-1:0] data);
    return saved == data;
  endfunction

  assign entry_evt    = (st_q == S_ARMED) && ev_sc && hit_arm && !blocked;
  assign blocked_evt  = (st_q == S_ARMED) && ev_sc && hit_arm && blocked;
  assign release_evt  = (st_q == S_SPEC) && ev_st && hit_lock &&
                        restores(lock_val, ret_stdata) && !cause_any;
  assign mismatch_evt = (st_q == S_SPEC) && ev_st && hit_lock &&
                        !restores(lock_val, ret_stdata);
  assign ne_clr       = (st_q == S_HELD) && ev_st && hit_lock &&
                        restores(lock_val, ret_stdata);

  always_comb begin
    st_d     = st_q;
    commit_d = 1'b0;
    abort_d  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (ev_ll) st_d = S_ARMED;
      end
      S_ARMED: begin
        if (ev_ll)                st_d = S_ARMED;
        else if (entry_evt)       st_d = S_SPEC;
        else if (blocked_evt)     st_d = S_HELD;
        else if (ev_sc)           st_d = S_IDLE;
        else if (ev_st && hit_arm) st_d = S_IDLE;
      end
      S_SPEC: begin
        if (cause_any || mismatch_evt) begin
          abort_d = 1'b1;
          st_d    = S_IDLE;
        end else if (release_evt) begin
          commit_d = 1'b1;
          st_d     = S_IDLE;
        end
      end
      S_HELD: begin
        if (ne_clr) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign ne_set = abort_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      arm_addr   <= '0;
      arm_val    <= '0;
      lock_addr  <= '0;
      lock_val   <= '0;
      commit     <= 1'b0;
      abort_lock <= 1'b0;
    end else begin
      st_q       <= st_d;
      commit     <= commit_d;
      abort_lock <= abort_d;
      if ((st_q == S_IDLE || st_q == S_ARMED) && ev_ll) begin
        arm_addr <= ret_addr;
        arm_val  <= ret_ldval;
      end
      if (entry_evt || blocked_evt) begin
        lock_addr <= arm_addr;
        lock_val  <= arm_val;
      end
    end
  end

  assign spec_mode   = (st_q == S_SPEC);
  assign elide_store = entry_evt || release_evt;

  // R2: an elided acquire opens the speculative section
  p_entry_spec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt |=> spec_mode);

  // R6: a wrong release value aborts
  p_mismatch_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> abort_lock);

  // R7 / R8: any cause while speculating aborts next cycle
  p_cause_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_mode && cause_any) |=> (abort_lock && !spec_mode));

  // R5: commit only right after speculation and ends it
  p_commit_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!spec_mode && $past(spec_mode)));

endmodule

// File: rtl/lock_elide_ctrl.sv
module lock_elide_ctrl
  import lock_elide_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [2:0]        ret_kind,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [DATA_W-1:0] ret_ldval,
  input  logic [DATA_W-1:0] ret_stdata,
  input  logic              ret_uncached,
  input  logic              conflict,
  input  logic              buf_full,
  input  logic              untracked_evt,
  output logic              elide_store,
  output logic              spec_mode,
  output logic              commit,
  output logic              abort_lock
);

  logic              ev_ll, ev_sc, ev_st, hit_arm, hit_lock;
  logic              cause_any, blocked;
  logic              ne_set, ne_clr, entry_evt, blocked_evt;
  logic [ADDR_W-1:0] arm_addr, lock_addr;

  lock_elide_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ret_valid (ret_valid),
    .ret_kind  (ret_kind),
    .ret_addr  (ret_addr),
    .arm_addr  (arm_addr),
    .lock_addr (lock_addr),
    .ev_ll     (ev_ll),
    .ev_sc     (ev_sc),
    .ev_st     (ev_st),
    .hit_arm   (hit_arm),
    .hit_lock  (hit_lock)
  );

  lock_elide_causes u_cause (
    .ret_valid     (ret_valid),
    .ret_uncached  (ret_uncached),
    .conflict      (conflict),
    .buf_full      (buf_full),
    .untracked_evt (untracked_evt),
    .cause_any     (cause_any)
  );

  lock_elide_block #(.ADDR_W(ADDR_W)) u_blk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (ne_set),
    .set_addr   (lock_addr),
    .clr_en     (ne_clr),
    .query_addr (arm_addr),
    .blocked    (blocked)
  );

  lock_elide_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_addr    (ret_addr),
    .ret_ldval   (ret_ldval),
    .ret_stdata  (ret_stdata),
    .ev_ll       (ev_ll),
    .ev_sc       (ev_sc),
    .ev_st       (ev_st),
    .hit_arm     (hit_arm),
    .hit_lock    (hit_lock),
    .cause_any   (cause_any),
    .blocked     (blocked),
    .arm_addr    (arm_addr),
    .lock_addr   (lock_addr),
    .elide_store (elide_store),
    .spec_mode   (spec_mode),
    .commit      (commit),
    .abort_lock  (abort_lock),
    .ne_set      (ne_set),
    .ne_clr      (ne_clr),
    .entry_evt   (entry_evt),
    .blocked_evt (blocked_evt)
  );

  // R11: pulses never overlap
  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort_lock));

  // R11: each pulse lasts one cycle
  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort_lock) |=> !(commit || abort_lock));

  // R3: only a retiring store can be suppressed
  p_elide_store_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    elide_store |-> (ret_valid && is_store_kind(ret_kind)));

  // R9: a blocked acquire runs without speculation
  p_blocked_nospec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_evt |=> !spec_mode);

endmodule

// File: tb/sim_lock_elide_ctrl.sv
`timescale 1ns/1ps
module sim_lock_elide_ctrl;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ret_valid = 1'b0;
  logic [2:0]    ret_kind = 3'd0;
  logic [AW-1:0] ret_addr = '0;
  logic [DW-1:0] ret_ldval = '0;
  logic [DW-1:0] ret_stdata = '0;
  logic          ret_uncached = 1'b0;
  logic          conflict = 1'b0;
  logic          buf_full = 1'b0;
  logic          untracked_evt = 1'b0;
  logic          elide_store, spec_mode, commit, abort_lock;

  int n_chk = 0;
  int n_bad = 0;
  logic g_el, g_sp, g_cm, g_ab;

  always #2 clk = ~clk;

  lock_elide_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
    .ret_addr(ret_addr), .ret_ldval(ret_ldval), .ret_stdata(ret_stdata),
    .ret_uncached(ret_uncached), .conflict(conflict), .buf_full(buf_full),
    .untracked_evt(untracked_evt), .elide_store(elide_store),
    .spec_mode(spec_mode), .commit(commit), .abort_lock(abort_lock)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  // drive one cycle (called at negedge); c = {untracked, uncached, full, conflict}
  task automatic op(input logic [2:0] k, input logic [AW-1:0] a,
                    input logic [DW-1:0] ld, input logic [DW-1:0] sd,
                    input logic [3:0] c);
    ret_valid     = (k != 3'd0);
    ret_kind      = k;
    ret_addr      = a;
    ret_ldval     = ld;
    ret_stdata    = sd;
    conflict      = c[0];
    buf_full      = c[1];
    ret_uncached  = c[2];
    untracked_evt = c[3];
    #1 g_el = elide_store;
    @(posedge clk);
    #1;
    g_sp = spec_mode; g_cm = commit; g_ab = abort_lock;
    @(negedge clk);
    ret_valid = 1'b0; ret_kind = 3'd0;
    conflict = 1'b0; buf_full = 1'b0; ret_uncached = 1'b0; untracked_evt = 1'b0;
  endtask

  task automatic idle();
    op(3'd0, '0, '0, '0, 4'b0);
  endtask

  // acquire pattern; expected elision given
  task automatic acquire(input logic [AW-1:0] a, input logic [DW-1:0] v,
                         input logic exp_el, input string req);
    op(3'd3, a, v, '0, 4'b0);
    op(3'd4, a, '0, v + 16'd1, 4'b0);
    chk(req, g_el, exp_el);
    chk(req, g_sp, exp_el);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", elide_store, 1'b0); chk("R1", spec_mode, 1'b0);
    chk("R1", commit, 1'b0);      chk("R1", abort_lock, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R5 sweep of addresses and lock values
    for (int a = 0; a < 6; a++) begin
      for (int v = 0; v < 3; v++) begin
        acquire(AW'(a * 37 + 2), DW'(v * 5), 1'b1, "R2");
        op(3'd2, AW'(a * 37 + 200), '0, DW'(v * 5), 4'b0);
        chk("R5 other-addr store", g_el, 1'b0);
        chk("R5 still spec", g_sp, 1'b1);
        op(3'd2, AW'(a * 37 + 2), '0, DW'(v * 5), 4'b0);
        chk("R5 release elided", g_el, 1'b1);
        chk("R5 commit", g_cm, 1'b1);
        chk("R5 spec off", g_sp, 1'b0);
        chk("R11 no abort", g_ab, 1'b0);
        idle();
        chk("R11 commit single", g_cm, 1'b0);
      end
    end

    // R3 plain load does not arm
    op(3'd1, 16'h0050, 16'h0, '0, 4'b0);
    op(3'd4, 16'h0050, '0, 16'h1, 4'b0);
    chk("R3 load+sc elide", g_el, 1'b0); chk("R3 load+sc spec", g_sp, 1'b0);
    // R3 intervening store disarms
    op(3'd3, 16'h0051, 16'h0, '0, 4'b0);
    op(3'd2, 16'h0051, '0, 16'h7, 4'b0);
    op(3'd4, 16'h0051, '0, 16'h1, 4'b0);
    chk("R3 disarm elide", g_el, 1'b0); chk("R3 disarm spec", g_sp, 1'b0);

    // R4 mismatched address
    for (int d = 1; d < 4; d++) begin
      op(3'd3, 16'h0060, 16'h0, '0, 4'b0);
      op(3'd4, 16'(16'h0060 + d), '0, 16'h1, 4'b0);
      chk("R4 elide", g_el, 1'b0); chk("R4 spec", g_sp, 1'b0);
    end

    // R6 wrong release value, then R9 / R10 retry path
    acquire(16'h0070, 16'h0003, 1'b1, "R6 entry");
    op(3'd2, 16'h0070, '0, 16'h0009, 4'b0);
    chk("R6 not elided", g_el, 1'b0);
    chk("R6 abort", g_ab, 1'b1); chk("R6 spec off", g_sp, 1'b0);
    idle(); chk("R11 abort single", g_ab, 1'b0);
    // R9: other address still elided
    acquire(16'h0071, 16'h0000, 1'b1, "R9 other addr");
    op(3'd2, 16'h0071, '0, 16'h0000, 4'b0);
    chk("R9 other commit", g_cm, 1'b1);
    acquire(16'h0070, 16'h0003, 1'b0, "R9 blocked");
    op(3'd2, 16'h0070, '0, 16'h0003, 4'b0);
    chk("R10 real release not elided", g_el, 1'b0);
    chk("R10 no commit", g_cm, 1'b0);
    acquire(16'h0070, 16'h0003, 1'b1, "R10 elided again");
    op(3'd2, 16'h0070, '0, 16'h0003, 4'b0);
    chk("R10 commit", g_cm, 1'b1);

    // R7 / R8 each cause, at several critical-section depths
    for (int c = 0; c < 4; c++) begin
      for (int depth = 0; depth < 3; depth++) begin
        logic [AW-1:0] la;
        la = AW'(16'h0100 + c * 8 + depth);
        acquire(la, 16'h0000, 1'b1, (c < 2) ? "R7 entry" : "R8 entry");
        for (int k = 0; k < depth; k++) idle();
        op((c == 2) ? 3'd1 : 3'd0, 16'h0900, '0, '0, 4'(1 << c));
        chk((c < 2) ? "R7 abort" : "R8 abort", g_ab, 1'b1);
        chk((c < 2) ? "R7 spec off" : "R8 spec off", g_sp, 1'b0);
        chk("R11 excl", g_cm, 1'b0);
        acquire(la, 16'h0000, 1'b0, "R9 after cause");
        op(3'd2, la, '0, 16'h0000, 4'b0);
        chk("R10 clear", g_el, 1'b0);
      end
    end

    // R11 release coinciding with conflict: abort wins
    acquire(16'h0200, 16'h0004, 1'b1, "R11 entry");
    op(3'd2, 16'h0200, '0, 16'h0004, 4'b0001);
    chk("R11 no elide", g_el, 1'b0);
    chk("R11 abort", g_ab, 1'b1); chk("R11 no commit", g_cm, 1'b0);
    acquire(16'h0200, 16'h0004, 1'b0, "R11 blocked");
    op(3'd2, 16'h0200, '0, 16'h0004, 4'b0);

    // R12 causes outside speculation are ignored
    for (int c = 0; c < 4; c++) begin
      op(3'd0, '0, '0, '0, 4'(1 << c));
      chk("R12 idle abort", g_ab, 1'b0);
      op(3'd3, 16'h0300, 16'h0, '0, 4'b0);
      op(3'd0, '0, '0, '0, 4'(1 << c));
      chk("R12 armed abort", g_ab, 1'b0);
      op(3'd4, 16'h0300, '0, 16'h1, 4'b0);
      chk("R12 still elides", g_el, 1'b1);
      op(3'd2, 16'h0300, '0, 16'h0, 4'b0);
      chk("R12 commit", g_cm, 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule